// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control of a 12-bit successive-approximation converter. While idle it keeps the sampling path tracking the input. When a start pulse arrives it either goes straight to hold, or, in a mode kept for older designs, keeps tracking for a fixed number of clocks first. It then resolves the code one bit at a time, starting at the most significant bit. For each step it presents a trial code to an external DAC/comparator model and keeps or clears the bit under test according to the comparator answer.

The length of the conversion is chosen per conversion by a flag that is captured when the start is accepted. In the long form all twelve bits are tested. In the short form testing ends after eight bits and the four lowest result bits stay zero. All timing is counted in clocks of one system clock. The number of clocks spent on each bit and the length of the pre-conversion acquisition window are parameters. A busy output marks the conversion. A one-clock done pulse marks the moment the result register takes the new code.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, busy_o, done_o, trial_o and result_o are all 0 and sample_o is 1.
- R2: A long conversion (short_i=0 at start) tests bits 11 down to 0, one bit per CLKS_PER_BIT clocks. A tested bit is kept when cmp_i is 1 during its step and cleared when cmp_i is 0. With cmp_i = (input code >= trial_o), result_o equals the input code.
- R3: A short conversion (short_i=1 at start) tests only bits 11 down to 4. result_o[3:0] is then 0, and result_o equals the input code with its four low bits cleared.
- R4: With emul_i=0 at start, sample_o is 0 from the first clock after the start is accepted. busy_o stays high for N*CLKS_PER_BIT+1 clocks, where N is 12 or 8.
- R5: With emul_i=1 at start, sample_o stays 1 for the first ACQ_CLKS clocks of busy and is 0 during bit testing. busy_o stays high for ACQ_CLKS+N*CLKS_PER_BIT+1 clocks.
- R6: sample_o returns to 1 in the last clock of busy, one clock before busy_o falls, so that tracking restarts as soon as bit testing ends.
- R7: busy_o falls in the same clock in which result_o shows the new code and done_o is 1. done_o lasts exactly one clock.
- R8: result_o holds its value from one completion until the next.
- R9: A start pulse while busy_o is high is ignored, together with the short_i and emul_i values it carries. The running conversion keeps its length and result.
- R10: trial_o is 0 whenever no bit is under test. The first trial code of every conversion is 0x800, the MSB alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Convert command, one clock, accepted only when idle |
| short_i | input | 1 | 1 selects the 8-bit conversion; captured at start |
| emul_i | input | 1 | 1 inserts the acquisition window before bit testing |
| cmp_i | input | 1 | Comparator decision, 1 keeps the bit under test |
| busy_o | output | 1 | High while a conversion is running |
| sample_o | output | 1 | High while the input is being tracked, low while held |
| done_o | output | 1 | One-clock pulse with the result update |
| trial_o | output | RES_BITS | Trial code toward the DAC model |
| result_o | output | RES_BITS | Last completed conversion result |

## Verification
The bench sweeps input codes across the full range for both lengths and both modes, using an ideal comparator. A design that stops on the wrong bit, or that clears kept bits, produces results off by powers of two, or leaves non-zero low bits after a short conversion. The bench counts busy clocks and checks the tracking pattern clock by clock. This catches a missing or wrongly sized acquisition window, and it catches tracking that restarts only after busy falls. Start pulses with flipped length and mode flags are injected mid-conversion, which exposes a sequencer that restarts or relatches while busy.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACQ  = 2'd1,
      ST_TEST = 2'd2,
      ST_FIN  = 2'd3
   } sar_state_e;
endpackage

// File: rtl/sar_pace.sv
// Step timer: raises tick on the last clock of a window of lim clocks.
module sar_pace #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [CW-1:0] lim,
   output logic          tick
);
   logic [CW-1:0] cnt_q;

   assign tick = en && (cnt_q == lim - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (en) begin
         if (tick)      cnt_q <= '0;
         else           cnt_q <= cnt_q + CW'(1);
      end
   end

   a_r2_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt_q < lim));
endmodule

// File: rtl/sar_reg.sv
// Working code and one-hot bit pointer of the approximation.
module sar_reg #(
   parameter int RES_BITS = 12,
   parameter int STOP_IDX = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic                keep,
   input  logic                short_len,
   output logic [RES_BITS-1:0] code,
   output logic [RES_BITS-1:0] trial,
   output logic                last_bit
);
   logic [RES_BITS-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= '0;
         mask_q <= '0;
      end else if (load) begin
         code   <= '0;
         mask_q <= {1'b1, {(RES_BITS-1){1'b0}}};
      end else if (step) begin
         if (keep) code <= code | mask_q;
         mask_q <= mask_q >> 1;
      end
   end

   for (genvar i = 0; i < RES_BITS; i++) begin : g_trial
      assign trial[i] = code[i] | mask_q[i];
   end

   assign last_bit = short_len ? mask_q[STOP_IDX] : mask_q[0];

   a_r2_pointer_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_q));
   a_r2_no_bit_below_pointer: assert property (@(posedge clk) disable iff (!rst_n)
      ((code & mask_q) == '0));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
   import sar_pkg::*;
#(
   parameter int RES_BITS     = 12,
   parameter int SHORT_BITS   = 8,
   parameter int CLKS_PER_BIT = 53,
   parameter int ACQ_CLKS     = 140
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                short_i,
   input  logic                emul_i,
   input  logic                cmp_i,
   output logic                busy_o,
   output logic                sample_o,
   output logic                done_o,
   output logic [RES_BITS-1:0] trial_o,
   output logic [RES_BITS-1:0] result_o
);
   localparam int MAXC     = (CLKS_PER_BIT > ACQ_CLKS) ? CLKS_PER_BIT : ACQ_CLKS;
   localparam int CW       = $clog2(MAXC + 1);
   localparam int STOP_IDX = RES_BITS - SHORT_BITS;
   localparam logic [CW-1:0] BIT_LIM = CW'(CLKS_PER_BIT);
   localparam logic [CW-1:0] ACQ_LIM = CW'(ACQ_CLKS);

   if (SHORT_BITS < 1 || SHORT_BITS >= RES_BITS) begin : g_bad_short
      $error("SHORT_BITS must lie between 1 and RES_BITS-1");
   end
   if (CLKS_PER_BIT < 1) begin : g_bad_cpb
      $error("CLKS_PER_BIT must be at least 1");
   end
   if (ACQ_CLKS < 0) begin : g_bad_acq
      $error("ACQ_CLKS must not be negative");
   end

   sar_state_e          state_q;
   logic                short_q;
   logic                acq_sel;
   logic                tick;
   logic                last_bit;
   logic [RES_BITS-1:0] code;
   logic [RES_BITS-1:0] trial;

   // With no acquisition window the emulation mode collapses onto immediate hold.
   if (ACQ_CLKS > 0) begin : g_acq
      assign acq_sel = emul_i;
   end else begin : g_no_acq
      assign acq_sel = 1'b0;
   end

   sar_pace #(.CW(CW)) u_pace (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == ST_IDLE),
      .en    ((state_q == ST_ACQ) || (state_q == ST_TEST)),
      .lim   ((state_q == ST_ACQ) ? ACQ_LIM : BIT_LIM),
      .tick  (tick)
   );

   sar_reg #(.RES_BITS(RES_BITS), .STOP_IDX(STOP_IDX)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      ((state_q == ST_IDLE) && start_i),
      .step      ((state_q == ST_TEST) && tick),
      .keep      (cmp_i),
      .short_len (short_q),
      .code      (code),
      .trial     (trial),
      .last_bit  (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         short_q  <= 1'b0;
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               short_q <= short_i;
               state_q <= acq_sel ? ST_ACQ : ST_TEST;
            end
            ST_ACQ:  if (tick) state_q <= ST_TEST;
            ST_TEST: if (tick && last_bit) state_q <= ST_FIN;
            ST_FIN: begin
               result_o <= code;
               done_o   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q != ST_IDLE);
   assign sample_o = (state_q != ST_TEST);
   assign trial_o  = (state_q == ST_TEST) ? trial : '0;

   a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(short_q));
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r7_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));
   a_r6_track_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(sample_o));
   a_r3_short_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && short_q) |-> (result_o[STOP_IDX-1:0] == '0));
   a_r10_idle_trial_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (trial_o == '0));
endmodule

// File: tb/tb_sar_sequencer.sv
`timescale 1ns/1ps
module tb_sar_sequencer;
   localparam int RB  = 12;
   localparam int SB  = 8;
   localparam int CPB = 2;
   localparam int ACQ = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          short_i = 1'b0;
   logic          emul_i = 1'b0;
   logic          cmp_i;
   logic          busy_o, sample_o, done_o;
   logic [RB-1:0] trial_o, result_o;
   int            vin = 0;
   int            checks = 0;
   int            fails = 0;

   always #2.5 clk = ~clk;

   assign cmp_i = (vin >= int'(trial_o));

   sar_sequencer #(.RES_BITS(RB), .SHORT_BITS(SB), .CLKS_PER_BIT(CPB), .ACQ_CLKS(ACQ)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_i), .emul_i(emul_i),
      .cmp_i(cmp_i), .busy_o(busy_o), .sample_o(sample_o), .done_o(done_o),
      .trial_o(trial_o), .result_o(result_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_conv(input int v, input bit sh, input bit em, input bit poke);
      int n, acq, blen, cnt, exp_res, prev_res;
      bit samp_ok, last_samp, trial_ok;
      n       = sh ? SB : RB;
      acq     = em ? ACQ : 0;
      blen    = acq + n * CPB + 1;
      exp_res = sh ? (v & 32'hFF0) : v;
      vin     = v;
      @(negedge clk);
      start_i = 1'b1; short_i = sh; emul_i = em;
      @(negedge clk);
      start_i = 1'b0; short_i = !sh; emul_i = !em;
      cnt = 0; samp_ok = 1'b1; last_samp = 1'b0; trial_ok = 1'b1;
      prev_res = int'(result_o);
      while (busy_o && cnt < 1000) begin
         if (cnt < acq)            samp_ok &= (sample_o == 1'b1);
         else if (cnt < blen - 1)  samp_ok &= (sample_o == 1'b0);
         if (cnt == acq)           trial_ok = (trial_o == 12'h800);
         if (cnt < blen - 1)       chk(int'(result_o) == prev_res, "R8 hold during run", int'(result_o), prev_res);
         last_samp = sample_o;
         start_i = (poke && (cnt == 4 || cnt == blen - 3));
         cnt++;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(cnt == blen, em ? "R5 busy length" : "R4 busy length", cnt, blen);
      chk(samp_ok, em ? "R5 tracking pattern" : "R4 hold pattern", samp_ok, 1);
      chk(last_samp == 1'b1, "R6 tracking before busy falls", last_samp, 1);
      chk(trial_ok, "R10 first trial is MSB", trial_ok, 1);
      chk(done_o == 1'b1, "R7 done with busy fall", done_o, 1);
      chk(int'(result_o) == exp_res, sh ? (poke ? "R9 R3 short result" : "R3 short result")
                                        : (poke ? "R9 R2 long result" : "R2 long result"),
          int'(result_o), exp_res);
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done one clock", done_o, 0);
      chk(int'(result_o) == exp_res, "R8 result held after done", int'(result_o), exp_res);
      chk(trial_o == '0 && !busy_o, "R10 idle trial zero", int'(trial_o), 0);
   endtask

   initial begin
      #100000000;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && done_o == 0, "R1 reset busy/done", {busy_o, done_o}, 0);
      chk(result_o == '0 && trial_o == '0, "R1 reset result/trial", int'(result_o), 0);
      chk(sample_o == 1'b1, "R1 reset tracking", sample_o, 1);
      rst_n = 1'b1;
      @(negedge clk);
      // corner codes
      run_conv(0, 0, 0, 0);
      run_conv(4095, 0, 0, 0);
      run_conv(2048, 0, 1, 0);
      run_conv(2047, 1, 0, 0);
      run_conv(15, 1, 1, 0);
      run_conv(16, 1, 0, 0);
      run_conv(4095, 1, 1, 0);
      // ignored starts while busy, with flipped flags
      run_conv(1234, 0, 0, 1);
      run_conv(3001, 1, 1, 1);
      run_conv(77, 0, 1, 1);
      // sweep over the code range in all four configurations
      for (int v = 0; v < 4096; v += 7) begin
         run_conv(v, 0, 0, 0);
         run_conv(v, 1, 0, 0);
         run_conv(v, 0, 1, 0);
         run_conv(4095 - v, 1, 1, 0);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule